// File: doc/BRIEF.md
# Banked Interrupt Controller with Set/Clear Enables

This block gathers the interrupt lines of a processor subsystem into one request output. Two banks of 32 peripheral lines and one bank of 8 local lines each have a mask of enable bits. A source counts as pending while its input line is high and its enable bit is set. The request output is high whenever any source in any bank is pending. Nothing is latched, so software silences a source at the peripheral that drives it.

Software reaches the block over a plain 32-bit register bus. Enables are never written as a whole word. Each bank has a write-one-to-set address and a write-one-to-clear address, so two pieces of software can each change their own bits without a read-modify-write race. One summary register shows the pending local sources. It also has one bit per peripheral bank that is high when that bank has anything pending, so a handler can often decide where to look with a single read.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, irq_o is 0 and bus_rdata is 0. irq_o stays 0 even with every source line high.
- R2: A write to offset 0x210 (peripheral bank 0), 0x214 (peripheral bank 1) or 0x218 (local bank, data bits 7:0) sets the enable bits where the data has a 1 and leaves the other enable bits as they were.
- R3: A write to offset 0x21C (bank 0), 0x220 (bank 1) or 0x224 (local bank, data bits 7:0) clears the enable bits where the data has a 1 and leaves the other enable bits as they were.
- R4: A read of offset 0x204 returns irq_src_i[31:0] AND the bank 0 enables. A read of offset 0x208 returns irq_src_i[63:32] AND the bank 1 enables. Bit n of each word stands for source n of that bank.
- R5: A read of offset 0x200 returns the local sources AND the local enables in bits 7:0. Bit 8 is the OR of the bank 0 pending bits and bit 9 is the OR of the bank 1 pending bits. Bits 31:10 read 0.
- R6: A read of either the set address or the clear address of a bank returns that bank's current enable mask. The local mask sits in bits 7:0 and the bits above it read 0.
- R7: Writes to the pending offsets 0x200, 0x204 and 0x208 change no enable bit.
- R8: irq_o is a register. It is 1 in the cycle after a cycle in which any pending bit of any bank was 1, and 0 otherwise, so it falls one cycle after the last pending source drops or is disabled.
- R9: A read of any offset other than the nine above returns 0. A write to any such offset changes no enable bit.
- R10: bus_rdata is a register. It shows the value selected by a read in the clock after bus_re, and it is 0 after any cycle without bus_re. A read in the same cycle as a write to the same address returns the mask as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 64 | Peripheral source levels: bits 31:0 are bank 0, bits 63:32 are bank 1 |
| local_src_i | input | 8 | Local source levels: timer, mailbox, doorbell 0, doorbell 1, halt 0, halt 1, bad access 1, bad access 0 (bit 0 upward) |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The set and clear paths are tried with masks that overlap earlier masks. This separates a true set or clear from a whole-word overwrite. Source patterns that are all ones, sparse patterns and the top bit of bank 1 show that each bank masks its own input slice and that each summary bit follows the right bank. A walk of single local sources, each enabled and then disabled, shows that irq_o rises and falls one cycle later for every source. Writes to the pending and unmapped offsets, followed by reads of every mask, show that those writes leave the masks alone. A read issued in the same cycle as a write shows that the read returns the mask from before the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int WORD_W   = 32;
  localparam int PEND_OFF = 'h200;
  localparam int SET_OFF  = 'h210;
  localparam int STRIDE   = 4;

  function automatic logic [WORD_W-1:0] w1s_w1c(input logic [WORD_W-1:0] cur,
                                                input logic [WORD_W-1:0] set_m,
                                                input logic [WORD_W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // Slot k of NSLOT slots: peripheral banks are 0..NSLOT-2, local bank is NSLOT-1.
  function automatic int pend_offset(input int k, input int nslot);
    return PEND_OFF + STRIDE * ((k + 1) % nslot);
  endfunction

  function automatic int set_offset(input int k);
    return SET_OFF + STRIDE * k;
  endfunction

  function automatic int clr_offset(input int k, input int nslot);
    return SET_OFF + STRIDE * (nslot + k);
  endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int ADDR_W = 12,
  parameter int NSLOT  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSLOT-1:0]  pend_hit,
  output logic [NSLOT-1:0]  set_hit,
  output logic [NSLOT-1:0]  clr_hit
);
  import irqc_pkg::*;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] P_OFF = ADDR_W'(pend_offset(k, NSLOT));
    localparam logic [ADDR_W-1:0] S_OFF = ADDR_W'(set_offset(k));
    localparam logic [ADDR_W-1:0] C_OFF = ADDR_W'(clr_offset(k, NSLOT));
    assign pend_hit[k] = (addr == P_OFF);
    assign set_hit[k]  = (addr == S_OFF);
    assign clr_hit[k]  = (addr == C_OFF);
  end

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  import irqc_pkg::*;

  localparam logic [WORD_W-1:0] ZERO = '0;

  logic [WORD_W-1:0] set_m, clr_m, nxt;

  assign set_m = set_stb ? WORD_W'(wdata) : ZERO;
  assign clr_m = clr_stb ? WORD_W'(wdata) : ZERO;
  assign nxt   = w1s_w1c(WORD_W'(en_q), set_m, clr_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_q <= '0;
    else if (set_stb || clr_stb) en_q <= nxt[W-1:0];
  end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  output logic [W-1:0] pend,
  output logic         any
);
  assign pend = src & en;
  assign any  = |pend;
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int LOCAL_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_src_i,
  input  logic [LOCAL_W-1:0]          local_src_i,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_re,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        irq_o
);
  localparam int NSLOT = NUM_BANKS + 1;
  localparam int LSLOT = NUM_BANKS;

  logic [NSLOT-1:0]        pend_hit, set_hit, clr_hit;
  logic [NSLOT-1:0]        set_stb, clr_stb;
  logic [NSLOT-1:0]        slot_any;
  logic [DATA_W-1:0]       en_word   [NSLOT];
  logic [DATA_W-1:0]       pend_word [NSLOT];
  logic [NSLOT*DATA_W-1:0] en_flat;
  logic [DATA_W-1:0]       rd_mux;
  logic                    any_pend;
  logic                    pend_wr_hit;

  irqc_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_dec (
    .addr(bus_addr), .pend_hit(pend_hit), .set_hit(set_hit), .clr_hit(clr_hit)
  );

  assign set_stb     = set_hit & {NSLOT{bus_we}};
  assign clr_stb     = clr_hit & {NSLOT{bus_we}};
  assign pend_wr_hit = bus_we & (|pend_hit);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [BANK_W-1:0] en_b, pend_b;
    irqc_enable_bank #(.W(BANK_W)) u_en (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb[k]), .clr_stb(clr_stb[k]),
      .wdata(bus_wdata[BANK_W-1:0]), .en_q(en_b)
    );
    irqc_pending #(.W(BANK_W)) u_pend (
      .src(irq_src_i[k*BANK_W +: BANK_W]), .en(en_b), .pend(pend_b), .any(slot_any[k])
    );
    assign en_word[k]   = DATA_W'(en_b);
    assign pend_word[k] = DATA_W'(pend_b);
  end

  logic [LOCAL_W-1:0] en_l, pend_l;
  irqc_enable_bank #(.W(LOCAL_W)) u_en_local (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb[LSLOT]), .clr_stb(clr_stb[LSLOT]),
    .wdata(bus_wdata[LOCAL_W-1:0]), .en_q(en_l)
  );
  irqc_pending #(.W(LOCAL_W)) u_pend_local (
    .src(local_src_i), .en(en_l), .pend(pend_l), .any(slot_any[LSLOT])
  );
  assign en_word[LSLOT]   = DATA_W'(en_l);
  assign pend_word[LSLOT] = DATA_W'({slot_any[NUM_BANKS-1:0], pend_l});

  for (genvar k = 0; k < NSLOT; k++) begin : g_flat
    assign en_flat[k*DATA_W +: DATA_W] = en_word[k];
  end

  assign any_pend = |slot_any;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (pend_hit[k])              rd_mux = rd_mux | pend_word[k];
      if (set_hit[k] || clr_hit[k]) rd_mux = rd_mux | en_word[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? rd_mux : '0;
      irq_o     <= any_pend;
    end
  end

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NSLOT  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_we,
  input logic                    bus_re,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic                    irq_o,
  input logic                    any_pend,
  input logic                    pend_wr_hit,
  input logic [NSLOT-1:0]        set_hit,
  input logic [NSLOT-1:0]        clr_hit,
  input logic [NSLOT*DATA_W-1:0] en_flat
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && bus_rdata == '0));

  a_r8_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq_o);

  a_r8_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq_o);

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && set_hit[0]) |=> ((en_flat[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && clr_hit[0]) |=> ((en_flat[DATA_W-1:0] & $past(bus_wdata)) == '0));

  a_r7_pending_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr_hit |=> $stable(en_flat));

  a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLOT(NSLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .any_pend(any_pend), .pend_wr_hit(pend_wr_hit),
  .set_hit(set_hit), .clr_hit(clr_hit), .en_flat(en_flat)
);

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_src_i = '0;
  logic [7:0]  local_src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string cur_tag = "R10";

  always #10 clk = ~clk;

  banked_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i), .local_src_i(local_src_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [31:0] m_en [3];
  logic [31:0] exp_rdata;
  logic        exp_irq;
  string       exp_tag;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] p0, p1, pl;
    if (!rst_n) begin
      m_en[0] = 0; m_en[1] = 0; m_en[2] = 0;
      exp_rdata = 0; exp_irq = 0; exp_tag = "R1";
    end else begin
      p0 = irq_src_i[31:0] & m_en[0];
      p1 = irq_src_i[63:32] & m_en[1];
      pl = {22'd0, (p1 != 0), (p0 != 0), local_src_i & m_en[2][7:0]};
      exp_irq = (p0 != 0) || (p1 != 0) || (pl[7:0] != 0);
      exp_tag = bus_re ? cur_tag : "R10";
      exp_rdata = 0;
      if (bus_re) begin
        case (bus_addr)
          12'h200: exp_rdata = pl;
          12'h204: exp_rdata = p0;
          12'h208: exp_rdata = p1;
          12'h210, 12'h21C: exp_rdata = m_en[0];
          12'h214, 12'h220: exp_rdata = m_en[1];
          12'h218, 12'h224: exp_rdata = m_en[2];
          default: exp_rdata = 0;
        endcase
      end
      if (bus_we) begin
        case (bus_addr)
          12'h210: m_en[0] = m_en[0] | bus_wdata;
          12'h214: m_en[1] = m_en[1] | bus_wdata;
          12'h218: m_en[2] = m_en[2] | {24'd0, bus_wdata[7:0]};
          12'h21C: m_en[0] = m_en[0] & ~bus_wdata;
          12'h220: m_en[1] = m_en[1] & ~bus_wdata;
          12'h224: m_en[2] = m_en[2] & ~{24'd0, bus_wdata[7:0]};
          default: ;
        endcase
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (bus_rdata !== exp_rdata) begin
        fails++;
        $display("FAIL %s rdata: actual %h expected %h", exp_tag, bus_rdata, exp_rdata);
      end
      tests++;
      if (irq_o !== exp_irq) begin
        fails++;
        $display("FAIL %s irq_o: actual %b expected %b", rst_n ? "R8" : "R1", irq_o, exp_irq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d; bus_re = 0;
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; bus_addr = a; bus_re = 1; bus_we = 0;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    cur_tag = tag; bus_addr = a; bus_re = 1; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_re = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(2);
    // R1: reset state, sources high but nothing enabled
    rd(12'h210, "R1"); rd(12'h218, "R1"); rd(12'h200, "R1");
    irq_src_i = '1; local_src_i = '1;
    idle(3);
    // R2: set with overlapping masks
    wr(12'h210, 32'h0000_000A); rd(12'h210, "R2");
    wr(12'h210, 32'h0000_0003); rd(12'h210, "R2");
    rd(12'h204, "R4");
    irq_src_i[31:0] = 32'h0000_0005;
    rd(12'h204, "R4");
    // R3: clear leaves other bits
    wr(12'h21C, 32'h0000_0002); rd(12'h21C, "R3"); rd(12'h210, "R6");
    // bank 1, top bit
    wr(12'h214, 32'h8000_0001); irq_src_i[63:32] = 32'h8000_0000;
    rd(12'h208, "R4"); rd(12'h220, "R6"); rd(12'h200, "R5");
    // local bank, upper data bits dropped
    wr(12'h218, 32'h0000_FF05); local_src_i = 8'h07;
    rd(12'h200, "R5"); rd(12'h224, "R6");
    wr(12'h224, 32'h0000_0004); rd(12'h218, "R3");
    // R7: pending registers are read-only
    wr(12'h200, '1); wr(12'h204, '1); wr(12'h208, '1);
    rd(12'h210, "R7"); rd(12'h214, "R7"); rd(12'h218, "R7");
    // R9: unmapped offsets
    wr(12'h20C, '1); wr(12'h228, '1); wr(12'h000, '1); wr(12'h212, '1);
    rd(12'h20C, "R9"); rd(12'h228, "R9"); rd(12'h212, "R9");
    rd(12'h210, "R9"); rd(12'h214, "R9"); rd(12'h218, "R9");
    // R10: read concurrent with write returns old mask
    rdwr(12'h210, 32'hF000_0000, "R10"); rd(12'h210, "R2");
    rdwr(12'h21C, 32'hF000_0000, "R10"); rd(12'h21C, "R3");
    // R8: clear everything, then walk single local sources
    wr(12'h21C, '1); wr(12'h220, '1); wr(12'h224, '1);
    rd(12'h200, "R5");
    irq_src_i = '0; local_src_i = '0;
    idle(2);
    for (int i = 0; i < 8; i++) begin
      wr(12'h218, 32'(1) << i);
      local_src_i = 8'(1) << i;
      idle(2);
      rd(12'h200, "R5");
      local_src_i = '0;
      idle(2);
      local_src_i = 8'(1) << i;
      idle(1);
      wr(12'h224, 32'(1) << i);
      idle(2);
    end
    // R8: each peripheral bank alone drives irq_o
    wr(12'h214, 32'h0001_0000); irq_src_i[48] = 1'b1; idle(2);
    rd(12'h200, "R5");
    irq_src_i[48] = 1'b0; idle(2);
    wr(12'h210, 32'h4000_0000); irq_src_i[30] = 1'b1; idle(2);
    wr(12'h21C, 32'h4000_0000); idle(2);
    idle(2);
    done = 1;
    summary();
  end
endmodule